// File: doc/BRIEF.md
# Virtual I/O Block with Activity Detect

This block lets a host, through a small register port clocked by the design clock, watch a set of design signals and drive a set of control bits into the design. Each monitored input is registered on the design clock. Beside the live value, every input bit has two sticky activity flags, one for rising and one for falling transitions. A slow poller therefore learns that a bit moved even when the bit changed and changed back between two reads. Reading the activity word returns the flags and clears them.

Each output bit normally holds a static level written by the host. The host can also load a 16-bit pattern per output bit and then launch a one-shot playback on a chosen set of bits. The pattern leaves LSB first, one bit per clock. When the last bit has gone out, those outputs return to the static level. All output bits come from one register stage, so a single host write updates every output on the same clock edge.

Register map, with a 4-bit word address: 0x0 sampled input value (read-only). 0x1 activity word: rising flags in bits [IN_W-1:0], falling flags in bits [2*IN_W-1:IN_W]; a read clears both. 0x2 static output level. 0x3 launch on write (data bits [OUT_W-1:0] select the bits that play), and on read the mask of bits still playing. 0x8+k pattern for output bit k. All other addresses read as zero and ignore writes.

Top module: `vio_core`

## Requirements
- R1: A read of address 0x0 returns, in bits [IN_W-1:0], the value of data_i sampled on the previous rising clock edge; the upper bits read as zero.
- R2: A 0-to-1 change of sampled input bit i sets activity bit i, and a 1-to-0 change sets activity bit IN_W+i. The flag is readable two clock edges after data_i changes.
- R3: Activity flags are sticky: a bit that pulses high for a single cycle leaves both its rising and falling flags set until they are read.
- R4: A read of address 0x1 (reg_re_i high) clears all activity flags at the closing clock edge, unless a transition is detected on that same edge, in which case that new flag survives.
- R5: The input level present when reset is released produces no activity flag.
- R6: A write to address 0x2 reaches out_o on the second rising edge after the write is presented: it is not visible one cycle after the write and is visible two cycles after it. The value reads back from 0x2.
- R7: Every bit of out_o changes on the same clock edge for a given host update.
- R8: A write to 0x8+k stores a 16-bit pattern for output bit k, and the pattern reads back from that address. A write of mask M to 0x3 makes each bit k in M drive pattern bit i on out_o[k] from the (i+2)-th edge after the write is presented, for i = 0..15, LSB first.
- R9: After the 16th pattern bit, each playing output holds the most recently written static level, including a level written during playback. The pattern does not repeat.
- R10: A read of 0x3 returns the mask of bits still playing, which is set for 16 cycles after the launch write and then reads zero.
- R11: Rewriting a pattern register during playback does not alter the pattern being played.
- R12: Writes to 0x0, 0x1 and to unmapped addresses change no readable state and no output, and unmapped addresses read as zero.
- R13: While rst_ni is low, out_o and every register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Design clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host write strobe |
| reg_re_i | input | 1 | Host read strobe; clears activity when reading 0x1 |
| reg_addr_i | input | 4 | Host word address |
| reg_wdata_i | input | DATA_W | Host write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| data_i | input | IN_W | Monitored design signals |
| out_o | output | OUT_W | Driven control bits |

## Verification
The bench goes after the single-cycle pulse, which a block that only compares the current value with the last read value would miss entirely, and after a transition that lands on the clearing read's edge, which an ordering that lets clear win would lose. It checks the level held through reset release, where a block comparing against a reset-zero history would report a false rising edge. For playback it checks every bit position against the LSB-first order, the exact cycle the outputs return to static, and a pattern rewrite plus a static write made mid-play. An off-by-one counter shows up as a 15- or 17-bit train, a design that plays from the live pattern register picks up the rewritten bits, and a looping train never returns to static.

// File: rtl/vio_pkg.sv
package vio_pkg;
  localparam int unsigned VIO_ADDR_W = 4;
  typedef logic [VIO_ADDR_W-1:0] vio_addr_t;

  localparam vio_addr_t ADDR_IN     = 4'h0;
  localparam vio_addr_t ADDR_ACT    = 4'h1;
  localparam vio_addr_t ADDR_STATIC = 4'h2;
  localparam vio_addr_t ADDR_PLAY   = 4'h3;
  localparam vio_addr_t ADDR_PAT    = 4'h8;
endpackage

// File: rtl/vio_in_monitor.sv
module vio_in_monitor #(
  parameter int unsigned IN_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] data_i,
  input  logic            clr_i,
  output logic [IN_W-1:0] value_o,
  output logic [IN_W-1:0] rise_o,
  output logic [IN_W-1:0] fall_o
);
  logic [IN_W-1:0] smp_q, prv_q;
  logic [1:0]      fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      prv_q  <= '0;
      fill_q <= '0;
    end else begin
      smp_q  <= data_i;
      prv_q  <= smp_q;
      fill_q <= {fill_q[0], 1'b1};
    end
  end

  // compare only once both history stages hold real samples
  logic armed;
  assign armed = fill_q[1];

  for (genvar i = 0; i < IN_W; i++) begin : g_cell
    logic rise_q, fall_q;
    logic up, dn;
    assign up = armed &  smp_q[i] & ~prv_q[i];
    assign dn = armed & ~smp_q[i] &  prv_q[i];

    // set wins over clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rise_q <= 1'b0;
        fall_q <= 1'b0;
      end else begin
        rise_q <= (rise_q & ~clr_i) | up;
        fall_q <= (fall_q & ~clr_i) | dn;
      end
    end

    assign rise_o[i] = rise_q;
    assign fall_o[i] = fall_q;
  end

  assign value_o = smp_q;
endmodule

// File: rtl/vio_out_driver.sv
module vio_out_driver #(
  parameter int unsigned OUT_W   = 4,
  parameter int unsigned PAT_LEN = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            static_we_i,
  input  logic [OUT_W-1:0]                static_d_i,
  input  logic [OUT_W-1:0]                pat_we_i,
  input  logic [PAT_LEN-1:0]              pat_d_i,
  input  logic                            go_i,
  input  logic [OUT_W-1:0]                go_mask_i,
  output logic [OUT_W-1:0]                static_o,
  output logic [OUT_W-1:0][PAT_LEN-1:0]   pat_o,
  output logic [OUT_W-1:0]                play_o,
  output logic [OUT_W-1:0]                out_o
);
  localparam int unsigned CNT_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_LEN - 1);

  logic [OUT_W-1:0] static_q, play_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      static_q <= '0;
      play_q   <= '0;
      cnt_q    <= '0;
    end else begin
      if (static_we_i) static_q <= static_d_i;
      if (go_i) begin
        play_q <= go_mask_i;
        cnt_q  <= '0;
      end else if (|play_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) play_q <= '0;
      end
    end
  end

  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    logic [PAT_LEN-1:0] pat_q, shf_q;
    logic               drv_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pat_q <= '0;
        shf_q <= '0;
        drv_q <= 1'b0;
      end else begin
        if (pat_we_i[k]) pat_q <= pat_d_i;
        // playback runs from a private copy taken at launch
        if (go_i && go_mask_i[k]) shf_q <= pat_q;
        else if (play_q[k])       shf_q <= shf_q >> 1;
        drv_q <= play_q[k] ? shf_q[0] : static_q[k];
      end
    end

    assign pat_o[k] = pat_q;
    assign out_o[k] = drv_q;
  end

  assign static_o = static_q;
  assign play_o   = play_q;
endmodule

// File: rtl/vio_core.sv
module vio_core
  import vio_pkg::*;
#(
  parameter int unsigned IN_W    = 8,
  parameter int unsigned OUT_W   = 4,
  parameter int unsigned PAT_LEN = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic                  reg_re_i,
  input  logic [VIO_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic [IN_W-1:0]       data_i,
  output logic [OUT_W-1:0]      out_o
);
  logic [IN_W-1:0]                in_val, rise, fall;
  logic [2*IN_W-1:0]              act_flags;
  logic                           act_clr;
  logic [OUT_W-1:0]               static_q, play_mask, pat_we;
  logic [OUT_W-1:0][PAT_LEN-1:0]  pat;
  logic                           static_we, go;
  logic                           unused_wdata;

  assign act_clr   = reg_re_i  && (reg_addr_i == ADDR_ACT);
  assign static_we = reg_we_i  && (reg_addr_i == ADDR_STATIC);
  assign go        = reg_we_i  && (reg_addr_i == ADDR_PLAY);
  assign unused_wdata = ^reg_wdata_i;

  for (genvar k = 0; k < OUT_W; k++) begin : g_pat_dec
    assign pat_we[k] = reg_we_i && (reg_addr_i == ADDR_PAT + vio_addr_t'(k));
  end

  vio_in_monitor #(.IN_W(IN_W)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .clr_i   (act_clr),
    .value_o (in_val),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign act_flags = {fall, rise};

  vio_out_driver #(.OUT_W(OUT_W), .PAT_LEN(PAT_LEN)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .static_we_i (static_we),
    .static_d_i  (reg_wdata_i[OUT_W-1:0]),
    .pat_we_i    (pat_we),
    .pat_d_i     (reg_wdata_i[PAT_LEN-1:0]),
    .go_i        (go),
    .go_mask_i   (reg_wdata_i[OUT_W-1:0]),
    .static_o    (static_q),
    .pat_o       (pat),
    .play_o      (play_mask),
    .out_o       (out_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_IN)     reg_rdata_o[IN_W-1:0]   = in_val;
    if (reg_addr_i == ADDR_ACT)    reg_rdata_o[2*IN_W-1:0] = act_flags;
    if (reg_addr_i == ADDR_STATIC) reg_rdata_o[OUT_W-1:0]  = static_q;
    if (reg_addr_i == ADDR_PLAY)   reg_rdata_o[OUT_W-1:0]  = play_mask;
    for (int k = 0; k < OUT_W; k++) begin
      if (reg_addr_i == ADDR_PAT + vio_addr_t'(k)) reg_rdata_o[PAT_LEN-1:0] = pat[k];
    end
  end
endmodule

// File: rtl/vio_core_chk.sv
module vio_core_chk
  import vio_pkg::*;
#(
  parameter int unsigned IN_W   = 8,
  parameter int unsigned OUT_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_we_i,
  input logic [VIO_ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0]     reg_wdata_i,
  input logic [DATA_W-1:0]     reg_rdata_o,
  input logic [IN_W-1:0]       data_i,
  input logic [OUT_W-1:0]      out_o,
  input logic [2*IN_W-1:0]     act_flags,
  input logic                  act_clr,
  input logic [OUT_W-1:0]      play_mask,
  input logic [OUT_W-1:0]      static_q
);
  logic started_q;
  logic unused_chk;
  assign unused_chk = ^{reg_wdata_i, reg_rdata_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  // R1
  in_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && reg_addr_i == ADDR_IN) |-> reg_rdata_o[IN_W-1:0] == $past(data_i));

  // R4
  act_clear_only_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(act_flags) & ~act_flags)) |-> $past(act_clr));

  // R10
  play_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|play_mask) |-> $past(reg_we_i && reg_addr_i == ADDR_PLAY));

  // R9
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(play_mask) == '0) |-> out_o == $past(static_q));

  // R6
  static_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_we_i && reg_addr_i == ADDR_STATIC) |-> static_q == $past(reg_wdata_i[OUT_W-1:0]));
endmodule

bind vio_core vio_core_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .data_i      (data_i),
  .out_o       (out_o),
  .act_flags   (act_flags),
  .act_clr     (act_clr),
  .play_mask   (play_mask),
  .static_q    (static_q)
);

// File: tb/vio_core_test.sv
module vio_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  data = 8'h81;
  logic [3:0]  out;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  vio_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .data_i(data), .out_o(out)
  );

  // {din, expected rise, expected fall}, starting from a sampled value of 00
  localparam logic [23:0] VECS [8] = '{
    {8'hA5, 8'hA5, 8'h00}, {8'h5A, 8'h5A, 8'hA5}, {8'h5A, 8'h00, 8'h00},
    {8'hFF, 8'hA5, 8'h00}, {8'h00, 8'h00, 8'hFF}, {8'h3C, 8'h3C, 8'h00},
    {8'hC3, 8'hC3, 8'h3C}, {8'hC3, 8'h00, 8'h00}
  };
  localparam logic [15:0] PAT0 = 16'hB38D;
  localparam logic [15:0] PAT2 = 16'hC0A5;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    #1 chk("R13 out_o in reset", {28'h0, out}, 32'h0);
    reg_addr = 4'h2; #1 chk("R13 static in reset", reg_rdata, 32'h0);
    reg_addr = 4'h3; #1 chk("R13 play in reset", reg_rdata, 32'h0);
    reg_addr = 4'h1; #1 chk("R13 activity in reset", reg_rdata, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'h1, d); chk("R5 no activity from reset level", d, 32'h0);
    rd(4'h0, d); chk("R1 value after reset", d, 32'h81);
    data = 8'h00;
    repeat (2) @(negedge clk);
    rd(4'h1, d); chk("R2 falling flags", d, 32'h8100);

    // table-driven activity and value checks
    for (int v = 0; v < 8; v++) begin
      data = VECS[v][23:16];
      repeat (2) @(negedge clk);
      rd(4'h1, d); chk("R2 activity vector", d, {16'h0, VECS[v][7:0], VECS[v][15:8]});
      rd(4'h0, d); chk("R1 sampled value", d, {24'h0, VECS[v][23:16]});
    end

    // R3: single-cycle pulses on bit 4
    data = 8'hD3; @(negedge clk); data = 8'hC3; @(negedge clk);
    data = 8'hD3; @(negedge clk); data = 8'hC3;
    repeat (3) @(negedge clk);
    rd(4'h1, d); chk("R3 sticky rise and fall", d, 32'h1010);
    rd(4'h1, d); chk("R4 cleared by read", d, 32'h0);

    // R4: transition detected on the clearing edge survives
    data = 8'hC7; @(negedge clk);
    rd(4'h1, d); chk("R4 before same-edge set", d, 32'h0);
    rd(4'h1, d); chk("R4 same-edge set survives", d, 32'h0004);

    // R12: read-only and unmapped writes
    wr(4'h0, 32'hFFFF_FFFF); wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h5, 32'hFFFF_FFFF); wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R12 value unchanged", d, 32'hC7);
    rd(4'h1, d); chk("R12 activity unchanged", d, 32'h0);
    rd(4'h5, d); chk("R12 unmapped reads zero", d, 32'h0);
    rd(4'hC, d); chk("R12 unmapped pattern slot zero", d, 32'h0);
    rd(4'h2, d); chk("R12 static unchanged", d, 32'h0);
    #1 chk("R12 outputs unchanged", {28'h0, out}, 32'h0);

    // R6/R7 static write latency, all bits together
    reg_addr = 4'h2; reg_wdata = 32'hA; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    #1 chk("R6 not yet after one edge", {28'h0, out}, 32'h0);
    @(negedge clk);
    #1 chk("R6 static reaches out_o", {28'h0, out}, 32'hA);
    reg_addr = 4'h2; reg_wdata = 32'h5; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    #1 chk("R7 no bit moves early", {28'h0, out}, 32'hA);
    @(negedge clk);
    #1 chk("R7 all bits flip together", {28'h0, out}, 32'h5);
    rd(4'h2, d); chk("R6 static readback", d, 32'h5);

    // R8-R11 one-shot playback on bits 0 and 2
    wr(4'h8, {16'h0, PAT0});
    wr(4'hA, {16'h0, PAT2});
    rd(4'h8, d); chk("R8 pattern readback", d, {16'h0, PAT0});
    reg_addr = 4'h3; reg_wdata = 32'h5; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    for (int j = 1; j <= 17; j++) begin
      #1;
      if (j != 5 && j != 6)
        chk("R10 play mask", reg_rdata, (j <= 16) ? 32'h5 : 32'h0);
      if (j >= 2) begin
        chk(j >= 6 ? "R11 bit0 keeps old pattern" : "R8 bit0 pattern",
            {31'h0, out[0]}, {31'h0, PAT0[j-2]});
        chk("R8 bit2 pattern", {31'h0, out[2]}, {31'h0, PAT2[j-2]});
      end
      if (j == 4) begin reg_we = 1'b1; reg_addr = 4'h8; reg_wdata = 32'hFFFF; end
      if (j == 5) begin reg_addr = 4'h2; reg_wdata = 32'hA; end
      if (j == 6) begin reg_we = 1'b0; reg_addr = 4'h3; end
      @(negedge clk);
    end
    #1 chk("R9 return to latest static", {28'h0, out}, 32'hA);
    chk("R10 mask clear after play", reg_rdata, 32'h0);
    repeat (20) @(negedge clk);
    #1 chk("R9 no repeat", {28'h0, out}, 32'hA);
    rd(4'h3, d); chk("R9 still idle", d, 32'h0);
    rd(4'h8, d); chk("R11 rewritten pattern stored", d, 32'hFFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule